// File: doc/BRIEF.md
# Four-Channel Compare Timer with Reset Watchdog

The block keeps one free-running up-counter that advances by one on every clock cycle in which the tick-enable input is high. The tick comes from a prescaler outside the block. Four match registers are compared against the count. When the counter steps onto a match value and that channel's interrupt is enabled, the channel latches a sticky status flag. Its interrupt line follows that flag until software writes a 1 to the flag's status bit.

The last match channel also serves as a one-shot watchdog. If software has armed the watchdog, a match on that channel raises a reset request for exactly one clock cycle and disarms the watchdog in the same cycle. Software re-arms it by writing the enable again.

All state is reached through a single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the address. Software can write the counter at any time, and counting then continues from the written value.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero: the match values, the counter, the status, the watchdog enable and the interrupt enable. All interrupt lines and the reset request are low.
- R2: Each clock edge with `tick_en` high adds one to the counter, which wraps from 0xFFFFFFFF to 0. Reads of byte offset 0x10 return the counter.
- R3: A write to offset 0x10 loads the counter. This load takes priority over a tick in the same cycle. Later ticks count up from the loaded value. A load by itself never produces a match.
- R4: Match value n is at offset 0x00 + 4·n. If a tick moves the counter onto match value n while interrupt-enable bit n is set, status bit n is set on that same edge and `irq[n]` goes high.
- R5: If interrupt-enable bit n is clear when channel n matches, status bit n stays as it was and `irq[n]` does not rise.
- R6: The status register is at offset 0x14, with bit n for channel n. Each bit written as 1 is cleared, and each bit written as 0 is kept. `irq[n]` equals status bit n.
- R7: The interrupt-enable register is at offset 0x1C. It stores bits 11:0 of a write, and bits above 11 read back as zero. Bit n gates channel n.
- R8: The watchdog enable is at offset 0x18 and keeps only bit 0. When channel 3 matches while it is set, `reset_req` is high for exactly one cycle and the enable reads zero afterwards. This happens whatever the value of interrupt-enable bit 3.
- R9: A channel 3 match with the watchdog enable clear leaves `reset_req` low.
- R10: Reads of any offset not listed above return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable from the prescaler |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 4 | Per-channel interrupt lines |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its defaults: a 32-bit counter, four channels and a 12-bit interrupt-enable register. At this width, natural counting cannot reach interesting values within a run. The bench therefore writes the counter to land a tick or two before each match value. This brings the all-ones-to-zero wrap, the watchdog channel and a match right after a load within a few cycles. Having four channels lets one test combine enabled and disabled matches and clear some status bits while keeping others.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Byte offsets of the register port; the match registers sit at the bottom.
  localparam int MATCH_STRIDE = 4;
  localparam int OFF_CNT      = 'h10;
  localparam int OFF_STS      = 'h14;
  localparam int OFF_WDE      = 'h18;
  localparam int OFF_IEN      = 'h1C;

  function automatic int match_off(input int idx);
    return idx * MATCH_STRIDE;
  endfunction

  // Sticky flag update: a new event wins over a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         adv
);
  function automatic logic [W-1:0] step(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  assign cnt_nxt = step(cnt_q);
  // a load suppresses the tick for this cycle
  assign adv     = tick_en & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (adv)   cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mt_match_ch.sv
module mt_match_ch
  import mt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_match,
  input  logic [W-1:0] wdata,
  input  logic         adv,
  input  logic [W-1:0] cnt_nxt,
  input  logic         irq_en,
  input  logic         clr,
  output logic [W-1:0] match_q,
  output logic         hit,
  output logic         sts_q
);
  // hit: the counter is stepping onto the match value on this edge
  assign hit = adv && (cnt_nxt == match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (wr_match) match_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= flag_next(sts_q, hit & irq_en, clr);
  end
endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic fire_src,
  output logic wd_en_q,
  output logic reset_req
);
  logic fire;
  assign fire = fire_src & wd_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en_q   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= fire;
      // firing disarms, even over a write in the same cycle
      if (fire)       wd_en_q <= 1'b0;
      else if (wr_en) wd_en_q <= wr_bit;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int W      = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8,
  parameter int IEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic [N_CH-1:0]   irq,
  output logic              reset_req
);
  localparam int WD_CH = N_CH - 1;

  // write strobes
  logic            wr_cnt, wr_sts, wr_wde, wr_ien;
  logic [N_CH-1:0] wr_match;
  assign wr_cnt = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign wr_sts = bus_we && (bus_addr == ADDR_W'(OFF_STS));
  assign wr_wde = bus_we && (bus_addr == ADDR_W'(OFF_WDE));
  assign wr_ien = bus_we && (bus_addr == ADDR_W'(OFF_IEN));

  // named internal events, also used by the bound checker
  logic [W-1:0]     cnt_q, cnt_nxt;
  logic             adv;
  logic [N_CH-1:0]  hit_vec, sts_q, sts_clr;
  logic [W-1:0]     match_q [N_CH];
  logic [IEN_W-1:0] ien_q;
  logic             wd_en_q;

  assign sts_clr = wr_sts ? bus_wdata[N_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[IEN_W-1:0];
  end

  mt_counter #(.W(W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .adv      (adv)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign wr_match[k] = bus_we && (bus_addr == ADDR_W'(match_off(k)));
    mt_match_ch #(.W(W)) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_match (wr_match[k]),
      .wdata    (bus_wdata),
      .adv      (adv),
      .cnt_nxt  (cnt_nxt),
      .irq_en   (ien_q[k]),
      .clr      (sts_clr[k]),
      .match_q  (match_q[k]),
      .hit      (hit_vec[k]),
      .sts_q    (sts_q[k])
    );
  end

  mt_watchdog wd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_wde),
    .wr_bit    (bus_wdata[0]),
    .fire_src  (hit_vec[WD_CH]),
    .wd_en_q   (wd_en_q),
    .reset_req (reset_req)
  );

  assign irq = sts_q;

  // read mux; undefined offsets fall through to zero
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CNT)) bus_rdata = cnt_q;
    if (bus_addr == ADDR_W'(OFF_STS)) bus_rdata = W'(sts_q);
    if (bus_addr == ADDR_W'(OFF_WDE)) bus_rdata = W'(wd_en_q);
    if (bus_addr == ADDR_W'(OFF_IEN)) bus_rdata = W'(ien_q);
    for (int k = 0; k < N_CH; k++) begin
      if (bus_addr == ADDR_W'(match_off(k))) bus_rdata = match_q[k];
    end
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int W      = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [W-1:0]      bus_wdata,
  input logic [N_CH-1:0]   irq,
  input logic              reset_req,
  input logic [N_CH-1:0]   hit_vec,
  input logic [N_CH-1:0]   ien,
  input logic              wd_en_q,
  input logic [W-1:0]      cnt_q
);
  logic cnt_wr;
  assign cnt_wr = bus_we && (bus_addr == ADDR_W'(OFF_CNT));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(bus_wdata)));

  // R8
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R8
  wd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !wd_en_q);

  // R9
  reset_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wd_en_q && hit_vec[N_CH-1]));

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    // R4
    irq_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[k] && ien[k]) |=> irq[k]);
    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> $past(hit_vec[k] && ien[k]));
  end
endmodule

bind match_timer mt_checker #(.W(W), .N_CH(N_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .reset_req (reset_req),
  .hit_vec   (hit_vec),
  .ien       (ien_q[N_CH-1:0]),
  .wd_en_q   (wd_en_q),
  .cnt_q     (cnt_q)
);

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_IRQ = 1, K_RST = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  item_t mon_it;
  logic [31:0] mon_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .reset_req(reset_req)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      case (mon_it.kind)
        K_RD:    mon_act = bus_rdata;
        K_IRQ:   mon_act = {28'b0, irq};
        default: mon_act = {31'b0, reset_req};
      endcase
      checks++;
      if (mon_act !== mon_it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                 mon_it.req, mon_it.kind, bus_addr, mon_act, mon_it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic tick(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    bus_addr = a;
    sb_q.push_back('{K_RD, e, r});
    @(negedge clk); #1;
  endtask

  task automatic exp_pin(input int kind, input logic [31:0] e, input string r);
    sb_q.push_back('{kind, e, r});
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) exp_rd(8'(a * 4), 32'h0, "R1");
    exp_pin(K_IRQ, 32'h0, "R1");
    exp_pin(K_RST, 32'h0, "R1");

    // R4 enabled match on channel 0, R2 counting
    wr(8'h00, 32'd5); wr(8'h1C, 32'h1); wr(8'h10, 32'd3);
    tick(2);
    exp_rd(8'h10, 32'd5, "R2");
    exp_rd(8'h14, 32'h1, "R4");
    exp_pin(K_IRQ, 32'h1, "R4");

    // R5 disabled channel 1 leaves its bit alone
    wr(8'h04, 32'd8);
    tick(3);
    exp_rd(8'h10, 32'd8, "R2");
    exp_rd(8'h14, 32'h1, "R5");
    exp_pin(K_IRQ, 32'h1, "R5");

    // R6 write-one-to-clear
    wr(8'h14, 32'h1);
    exp_rd(8'h14, 32'h0, "R6");
    exp_pin(K_IRQ, 32'h0, "R6");

    // R3 load then count on
    wr(8'h08, 32'd102); wr(8'h1C, 32'h5); wr(8'h10, 32'd100);
    exp_rd(8'h10, 32'd100, "R3");
    tick(2);
    exp_rd(8'h10, 32'd102, "R3");
    exp_rd(8'h14, 32'h4, "R4");
    exp_pin(K_IRQ, 32'h4, "R4");

    // R6 selective clear
    wr(8'h10, 32'd4);
    tick(1);
    exp_rd(8'h14, 32'h5, "R4");
    wr(8'h14, 32'h4);
    exp_rd(8'h14, 32'h1, "R6");
    exp_pin(K_IRQ, 32'h1, "R6");
    wr(8'h14, 32'hFFFF_FFFF);
    exp_rd(8'h14, 32'h0, "R6");

    // R3 a load onto a match value is not a match
    wr(8'h10, 32'd5);
    exp_rd(8'h14, 32'h0, "R3");

    // R7 upper enable bits dropped
    wr(8'h1C, 32'hFFFF_F00F);
    exp_rd(8'h1C, 32'h0000_000F, "R7");

    // R8 watchdog fires once and disarms
    wr(8'h0C, 32'd20); wr(8'h18, 32'hFFFF_FFFF);
    exp_rd(8'h18, 32'h1, "R8");
    wr(8'h10, 32'd18);
    tick(1);
    exp_pin(K_RST, 32'h0, "R8");
    tick(1);
    exp_pin(K_RST, 32'h1, "R8");
    exp_pin(K_RST, 32'h0, "R8");
    exp_rd(8'h18, 32'h0, "R8");
    exp_rd(8'h14, 32'h8, "R4");
    exp_pin(K_IRQ, 32'h8, "R4");

    // R9 unarmed watchdog (bit 1 only written)
    wr(8'h14, 32'hF); wr(8'h18, 32'h2);
    exp_rd(8'h18, 32'h0, "R8");
    wr(8'h10, 32'd18);
    tick(2);
    exp_pin(K_RST, 32'h0, "R9");
    exp_rd(8'h14, 32'h8, "R9");

    // R8 watchdog independent of interrupt enable
    wr(8'h14, 32'hF); wr(8'h1C, 32'h0); wr(8'h18, 32'h1); wr(8'h10, 32'd18);
    tick(2);
    exp_pin(K_RST, 32'h1, "R8");
    exp_rd(8'h14, 32'h0, "R5");
    exp_rd(8'h18, 32'h0, "R8");

    // R2 wrap produces a match at zero
    wr(8'h1C, 32'h1); wr(8'h00, 32'h0); wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    exp_rd(8'h10, 32'h0, "R2");
    exp_rd(8'h14, 32'h1, "R2");

    // R10 undefined offsets
    exp_rd(8'h20, 32'h0, "R10");
    wr(8'h24, 32'hDEAD_BEEF);
    exp_rd(8'h1C, 32'h1, "R10");
    exp_rd(8'h00, 32'h0, "R10");
    exp_rd(8'h10, 32'h0, "R10");
    exp_rd(8'h14, 32'h1, "R10");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule